// File: doc/BRIEF.md
# I2C Register and FIFO Slave

This block is an I2C target for Standard-mode and Fast-mode buses. It lets a host reach a byte-wide register map and two byte FIFOs that sit between the host and a modem. The host transmit FIFO is filled over the bus and drained by the modem. The receive FIFO is filled by the modem and drained over the bus. SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The block drives SDA as an open-drain pull-down enable only.

A write transaction carries a subaddress byte and then data bytes. A read transaction sends no subaddress. It starts at the address held in a read-pointer register, which the host sets beforehand with a write to address 0x00. One address reads and pops the receive FIFO. Another address pushes the transmit FIFO. A command register moves FIFO pointers back to zero and leaves the stored bytes in place. A four-bit event register latches modem events and clears when the host reads it.

Top module: `i2c_regfifo_slave`

## Requirements
- R1: The block acknowledges only the 7-bit target address {0110, addr_pins[2:0]}, which gives 8-bit write addresses 0x60 to 0x6E in steps of 2. It leaves SDA released for any other address.
- R2: In a write, the first byte after the address is the subaddress. Each following byte goes to that register. After each accepted byte the subaddress increments, except at 0x02.
- R3: A read starts at the pointer held in register 0x00, which is written through the subaddress path. The pointer increments after each byte read, except while it holds 0x01.
- R4: Reading address 0x01 pops one byte from the 128-byte receive FIFO, oldest byte first. A read from the empty FIFO returns 0x00 and pops nothing.
- R5: Writing address 0x02 pushes a byte into the 128-byte transmit FIFO, and the modem sees the bytes in order. A byte written while the FIFO holds 128 bytes is NACKed and is not stored.
- R6: Writing code bits [2:0] to register 0x03 sets FIFO pointers to zero and leaves the stored bytes in place. The codes are: 001 receive read pointer, 010 receive write pointer, 011 transmit read pointer, 100 transmit write pointer, 111 all four. Codes 000, 101 and 110 do nothing.
- R7: Register 0x04 is a 4-bit event mask that resets to 0x08. Bits [7:4] read back as 0. It is driven on irq_mask.
- R8: Register 0x05 reads back the events latched from irq_event in bits [3:0] and clears to 0x00 when read. An event that arrives in the cycle of that read is kept.
- R9: Register 0x7E reads 0xB1 and register 0x7F reads 0x03.
- R10: Unmapped addresses read 0x00. Writes to them are ACKed and ignored.
- R11: A START restarts address reception from any state. A master NACK after a read byte ends the read.
- R12: SDA is driven only during an acknowledge slot or a read data bit, and it is released in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_pins | input | 3 | Strapped low target address bits |
| rx_push | input | 1 | Modem writes rx_data into the receive FIFO |
| rx_data | input | 8 | Byte from the modem |
| rx_full | output | 1 | Receive FIFO holds 128 bytes |
| tx_pop | input | 1 | Modem takes the head of the transmit FIFO |
| tx_data | output | 8 | Head of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO holds no bytes |
| irq_event | input | 4 | Modem event pulses, latched into register 0x05 |
| irq_mask | output | 4 | Contents of the mask register |

## Verification
A table of target addresses is tried against a fixed strap value. It includes the matching address, neighbours that differ only in the strapped bits, a wrong fixed high nibble and a set fourth bit, which separates a full compare from a partial one. Register bursts set out subaddress increment, the pointer holding at the FIFO addresses, the reset values and clear-on-read. FIFO patterns fill the transmit FIFO to exactly 128 bytes and then one more byte, drain the receive FIFO past empty, and rewind single pointers or all of them. The rewinds show whether a reset clears the contents or only moves the pointer.

// File: rtl/i2c_rf_pkg.sv
`timescale 1ns/1ps
package i2c_rf_pkg;
   localparam logic [3:0] TGT_HI   = 4'b0110;
   localparam logic [7:0] A_RDPTR  = 8'h00;
   localparam logic [7:0] A_RXF    = 8'h01;
   localparam logic [7:0] A_TXF    = 8'h02;
   localparam logic [7:0] A_FCTL   = 8'h03;
   localparam logic [7:0] A_MASK   = 8'h04;
   localparam logic [7:0] A_EVT    = 8'h05;
   localparam logic [7:0] A_ID     = 8'h7E;
   localparam logic [7:0] A_REV    = 8'h7F;
   localparam logic [7:0] ID_VAL   = 8'hB1;
   localparam logic [7:0] REV_VAL  = 8'h03;

   typedef enum logic [2:0] {
      LK_IDLE, LK_ADDR, LK_AACK, LK_WR, LK_WACK, LK_RD, LK_MACK
   } link_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain, sda_chain;
   logic              scl_q, sda_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_chain[i] <= 1'b1;
            sda_chain[i] <= 1'b1;
         end else if (i == 0) begin
            scl_chain[i] <= scl_i;
            sda_chain[i] <= sda_i;
         end else begin
            scl_chain[i] <= scl_chain[i-1];
            sda_chain[i] <= sda_chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_chain[STAGES-1];
         sda_q <= sda_chain[STAGES-1];
      end
   end

   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_chain[STAGES-1] & ~scl_q;
   assign scl_fall  = ~scl_chain[STAGES-1] & scl_q;
   assign start_det = scl_chain[STAGES-1] & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_chain[STAGES-1] & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_link.sv
`timescale 1ns/1ps
module i2c_link
   import i2c_rf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       sda_in,
   input  logic [2:0] addr_pins,
   output logic       wr_stb,
   output logic [7:0] wr_byte,
   output logic       wr_first,
   input  logic       wr_accept,
   output logic       rd_stb,
   input  logic [7:0] rd_byte,
   output logic       sda_oe
);
   link_st_t   st;
   logic [3:0] cnt;
   logic [7:0] rx_sh, tx_sh;
   logic       rw, first, nack;
   logic [6:0] own_addr;

   assign own_addr = {TGT_HI, addr_pins};
   assign wr_byte  = rx_sh;
   assign wr_first = first;
   assign wr_stb   = (st == LK_WR) && scl_fall && (cnt == 4'd8);
   assign rd_stb   = ((st == LK_AACK) && rw && scl_fall) ||
                     ((st == LK_MACK) && scl_fall && !nack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= LK_IDLE;
         cnt    <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         rw     <= 1'b0;
         first  <= 1'b0;
         nack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         st     <= LK_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         st     <= LK_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            LK_ADDR, LK_WR: begin
               if (scl_rise && cnt != 4'd8) begin
                  rx_sh <= {rx_sh[6:0], sda_in};
                  cnt   <= cnt + 4'd1;
               end else if (scl_fall && cnt == 4'd8) begin
                  if (st == LK_ADDR) begin
                     if (rx_sh[7:1] == own_addr) begin
                        rw     <= rx_sh[0];
                        first  <= 1'b1;
                        sda_oe <= 1'b1;
                        st     <= LK_AACK;
                     end else begin
                        st <= LK_IDLE;
                     end
                  end else begin
                     first  <= 1'b0;
                     sda_oe <= wr_accept;
                     st     <= LK_WACK;
                  end
               end
            end
            LK_AACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     tx_sh  <= rd_byte;
                     sda_oe <= ~rd_byte[7];
                     st     <= LK_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= LK_WR;
                  end
               end
            end
            LK_WACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  st     <= LK_WR;
               end
            end
            LK_RD: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     st     <= LK_MACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                     cnt    <= cnt + 4'd1;
                  end
               end
            end
            LK_MACK: begin
               if (scl_rise) begin
                  nack <= sda_in;
               end else if (scl_fall) begin
                  cnt <= '0;
                  if (nack) begin
                     st <= LK_IDLE;
                  end else begin
                     tx_sh  <= rd_byte;
                     sda_oe <= ~rd_byte[7];
                     st     <= LK_RD;
                  end
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end

   // R12: the line is never pulled while the link is idle
   p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_IDLE) |-> !sda_oe);

   // R1: a foreign address leaves the bus released
   p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_ADDR && scl_fall && cnt == 4'd8 && !start_det && !stop_det &&
       rx_sh[7:1] != own_addr) |=> (!sda_oe && st == LK_IDLE));
endmodule

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   input  logic             clr_rd,
   input  logic             clr_wr,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad
      $error("byte_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_p, wr_p, rd_n, wr_n;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full & ~clr_wr;
   assign do_pop  = pop & ~empty & ~clr_rd;
   assign head    = mem[rd_p];

   assign rd_n = clr_rd ? '0 : (do_pop  ? rd_p + AW'(1) : rd_p);
   assign wr_n = clr_wr ? '0 : (do_push ? wr_p + AW'(1) : wr_p);

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         rd_p <= rd_n;
         wr_p <= wr_n;
         if (clr_rd || clr_wr)
            cnt <= {1'b0, AW'(wr_n - rd_n)};
         else
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   // R5: nobody pushes into a full buffer
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
endmodule

// File: rtl/i2c_regfifo_slave.sv
`timescale 1ns/1ps
module i2c_regfifo_slave
   import i2c_rf_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 128,
   parameter int EVT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [2:0]       addr_pins,
   input  logic             rx_push,
   input  logic [7:0]       rx_data,
   output logic             rx_full,
   input  logic             tx_pop,
   output logic [7:0]       tx_data,
   output logic             tx_empty,
   input  logic [EVT_W-1:0] irq_event,
   output logic [EVT_W-1:0] irq_mask
);
   localparam logic [EVT_W-1:0] MASK_RST = EVT_W'(8);

   if (EVT_W < 4 || EVT_W > 8) begin : g_bad
      $error("i2c_regfifo_slave: EVT_W must lie in 4..8");
   end

   logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_stb, wr_first, wr_accept, rd_stb;
   logic [7:0] wr_byte, rd_byte;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_link u_link (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_in(sda_s),
      .addr_pins(addr_pins), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .wr_first(wr_first), .wr_accept(wr_accept), .rd_stb(rd_stb),
      .rd_byte(rd_byte), .sda_oe(sda_oe));

   logic [7:0]       sub_q, rdptr_q;
   logic [EVT_W-1:0] mask_q, evt_q;
   logic             reg_wr, tx_full, rx_empty, rx_pop;
   logic [7:0]       rx_head;
   logic             clr_rxr, clr_rxw, clr_txr, clr_txw, evt_clr;
   logic [2:0]       code;

   assign reg_wr    = wr_stb & ~wr_first;
   assign wr_accept = wr_first | ~((sub_q == A_TXF) & tx_full);
   assign code      = wr_byte[2:0];

   always_comb begin
      clr_rxr = 1'b0;
      clr_rxw = 1'b0;
      clr_txr = 1'b0;
      clr_txw = 1'b0;
      if (reg_wr && sub_q == A_FCTL) begin
         case (code)
            3'b001: clr_rxr = 1'b1;
            3'b010: clr_rxw = 1'b1;
            3'b011: clr_txr = 1'b1;
            3'b100: clr_txw = 1'b1;
            3'b111: begin
               clr_rxr = 1'b1;
               clr_rxw = 1'b1;
               clr_txr = 1'b1;
               clr_txw = 1'b1;
            end
            default: ;
         endcase
      end
   end

   byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(reg_wr && sub_q == A_TXF && !tx_full), .push_data(wr_byte),
      .pop(tx_pop), .clr_rd(clr_txr), .clr_wr(clr_txw),
      .head(tx_data), .full(tx_full), .empty(tx_empty));

   byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_data),
      .pop(rx_pop), .clr_rd(clr_rxr), .clr_wr(clr_rxw),
      .head(rx_head), .full(rx_full), .empty(rx_empty));

   assign rx_pop  = rd_stb & (rdptr_q == A_RXF) & ~rx_empty;
   assign evt_clr = rd_stb & (rdptr_q == A_EVT);

   always_comb begin
      case (rdptr_q)
         A_RDPTR: rd_byte = rdptr_q;
         A_RXF:   rd_byte = rx_empty ? 8'h00 : rx_head;
         A_MASK:  rd_byte = 8'(mask_q);
         A_EVT:   rd_byte = 8'(evt_q);
         A_ID:    rd_byte = ID_VAL;
         A_REV:   rd_byte = REV_VAL;
         default: rd_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         rdptr_q <= '0;
         mask_q  <= MASK_RST;
         evt_q   <= '0;
      end else begin
         if (wr_stb) begin
            if (wr_first) begin
               sub_q <= wr_byte;
            end else if (wr_accept) begin
               if (sub_q != A_TXF) sub_q <= sub_q + 8'd1;
               if (sub_q == A_MASK) mask_q <= wr_byte[EVT_W-1:0];
            end
         end
         if (reg_wr && sub_q == A_RDPTR)
            rdptr_q <= wr_byte;
         else if (rd_stb && rdptr_q != A_RXF)
            rdptr_q <= rdptr_q + 8'd1;
         evt_q <= (evt_clr ? '0 : evt_q) | irq_event;
      end
   end

   assign irq_mask = mask_q;

   // R8: a read of the event register empties it when nothing new arrives
   p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr && irq_event == '0) |=> (evt_q == '0));

   // R3: the pointer holds while it addresses the receive FIFO
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rdptr_q == A_RXF && !reg_wr) |=> (rdptr_q == A_RXF));

   // R5: a byte offered to a full transmit FIFO is refused on the bus
   p_full_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sub_q == A_TXF && tx_full) |=> !sda_oe);
endmodule

// File: tb/sim_i2c_regfifo_slave.sv
`timescale 1ns/1ps
module sim_i2c_regfifo_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 5 * CLK_PERIOD;
   localparam logic [2:0] PINS = 3'b101;
   localparam logic [7:0] WA = 8'h6A;
   localparam logic [7:0] RA = 8'h6B;
   // {address byte, expected acknowledge}
   localparam logic [8:0] ADDR_VEC [6] = '{
      {8'h6A, 1'b1}, {8'h68, 1'b0}, {8'h6E, 1'b0},
      {8'h2A, 1'b0}, {8'hEA, 1'b0}, {8'h7A, 1'b0}};

   logic clk = 0, rst_n = 0;
   logic scl_m = 1, sda_m = 1;
   logic sda_oe;
   logic rx_push = 0, tx_pop = 0;
   logic [7:0] rx_data = 0, tx_data;
   logic rx_full, tx_empty;
   logic [3:0] irq_event = 0, irq_mask;
   wire  sda_line = sda_m & ~sda_oe;

   int errors = 0, checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_regfifo_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .addr_pins(PINS), .rx_push(rx_push),
      .rx_data(rx_data), .rx_full(rx_full), .tx_pop(tx_pop),
      .tx_data(tx_data), .tx_empty(tx_empty), .irq_event(irq_event),
      .irq_mask(irq_mask));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic i2c_start();
      sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
   endtask

   task automatic i2c_stop();
      sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #Q;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; #Q; scl_m = 1; #Q; #Q; scl_m = 0; #Q;
      end
      sda_m = 1; #Q; scl_m = 1; #Q; ack = ~sda_line; #Q; scl_m = 0; #Q;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl_m = 1; #Q; b[i] = sda_line; #Q; scl_m = 0; #Q;
      end
      sda_m = nack; #Q; scl_m = 1; #Q; #Q; scl_m = 0; #Q; sda_m = 1;
   endtask

   task automatic wr_reg(input logic [7:0] sub, input logic [7:0] d);
      logic a;
      i2c_start(); send_byte(WA, a); send_byte(sub, a); send_byte(d, a); i2c_stop();
   endtask

   task automatic rd_at(input logic [7:0] p, output logic [7:0] d);
      logic a;
      wr_reg(8'h00, p);
      i2c_start(); send_byte(RA, a); recv_byte(1'b1, d); i2c_stop();
   endtask

   task automatic modem_push(input logic [7:0] d);
      @(negedge clk); rx_push = 1; rx_data = d;
      @(negedge clk); rx_push = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      #(CLK_PERIOD * 4) rst_n = 1;
      #(CLK_PERIOD * 4);

      // R12 reset: bus released
      chk("R12 idle release", sda_oe, 0);
      chk("R7 mask port reset", irq_mask, 4'h8);

      // R1 address table
      foreach (ADDR_VEC[k]) begin
         i2c_start(); send_byte(ADDR_VEC[k][8:1], a); i2c_stop();
         chk($sformatf("R1 address %0h", ADDR_VEC[k][8:1]), a, ADDR_VEC[k][0]);
      end

      // R7 reset value over the bus
      rd_at(8'h04, d); chk("R7 mask reset read", d, 8'h08);

      // R9 + R3 burst increments the pointer
      wr_reg(8'h00, 8'h7E);
      i2c_start(); send_byte(RA, a);
      recv_byte(1'b0, d); chk("R9 id", d, 8'hB1);
      recv_byte(1'b1, d); chk("R9 rev / R3 increment", d, 8'h03);
      i2c_stop();

      // R7 upper bits read zero
      wr_reg(8'h04, 8'hFF); rd_at(8'h04, d); chk("R7 mask width", d, 8'h0F);
      chk("R7 mask port", irq_mask, 4'hF);

      // R2 subaddress increments: 0x03 code 000, then 0x04
      i2c_start(); send_byte(WA, a); send_byte(8'h03, a);
      send_byte(8'h00, a); send_byte(8'h05, a); i2c_stop();
      rd_at(8'h04, d); chk("R2 subaddress increment", d, 8'h05);

      // R10 unmapped
      wr_reg(8'h40, 8'hAB); rd_at(8'h40, d); chk("R10 unmapped read", d, 8'h00);

      // R5 pushes stay at 0x02
      i2c_start(); send_byte(WA, a); send_byte(8'h02, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); i2c_stop();
      #1;
      chk("R5 tx head 1", tx_data, 8'h11);
      @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
      chk("R5 tx head 2", tx_data, 8'h22);
      @(negedge clk); tx_pop = 1; @(negedge clk); @(negedge clk); tx_pop = 0;
      chk("R5 tx drained", tx_empty, 1);

      // R5 fill to 128 then one more
      begin
         int bad = 0;
         i2c_start(); send_byte(WA, a); send_byte(8'h02, a);
         for (int i = 0; i < 128; i++) begin
            send_byte(8'(i + 8'h40), a);
            if (!a) bad++;
         end
         chk("R5 128 pushes acked", bad, 0);
         send_byte(8'hEE, a);
         chk("R5 full nack", a, 0);
         i2c_stop();
         chk("R5 first stored", tx_data, 8'h40);
         for (int i = 0; i < 127; i++) begin
            @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
         end
         chk("R5 last stored not 0xEE", tx_data, 8'hBF);
         @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
         chk("R5 empty after 128", tx_empty, 1);
      end

      // R4 rx pops, empty returns zero
      modem_push(8'hA1); modem_push(8'hA2); modem_push(8'hA3);
      wr_reg(8'h00, 8'h01);
      i2c_start(); send_byte(RA, a);
      recv_byte(1'b0, d); chk("R4 pop 1", d, 8'hA1);
      recv_byte(1'b0, d); chk("R4 pop 2", d, 8'hA2);
      recv_byte(1'b0, d); chk("R4 pop 3", d, 8'hA3);
      recv_byte(1'b1, d); chk("R4 empty reads zero", d, 8'h00);
      i2c_stop();

      // R6 rewind read pointer: same data again
      wr_reg(8'h03, 8'h01);
      wr_reg(8'h00, 8'h01);
      i2c_start(); send_byte(RA, a);
      recv_byte(1'b0, d); chk("R6 reread 1", d, 8'hA1);
      recv_byte(1'b1, d); chk("R6 reread 2", d, 8'hA2);
      i2c_stop();

      // R6 code 111 empties, code 010 rewinds writer
      wr_reg(8'h03, 8'h07);
      rd_at(8'h01, d); chk("R6 all pointers zero", d, 8'h00);
      modem_push(8'h5A); modem_push(8'h5B);
      wr_reg(8'h03, 8'h02);
      rd_at(8'h01, d); chk("R6 rx write rewind", d, 8'h00);
      modem_push(8'h77);
      rd_at(8'h01, d); chk("R6 slot zero rewritten", d, 8'h77);

      // R6 code 101 does nothing
      modem_push(8'h66);
      wr_reg(8'h03, 8'h05);
      rd_at(8'h01, d); chk("R6 code 101 ignored", d, 8'h66);

      // R8 latched events clear on read
      @(negedge clk); irq_event = 4'b0101; @(negedge clk); irq_event = 0;
      rd_at(8'h05, d); chk("R8 events latched", d, 8'h05);
      rd_at(8'h05, d); chk("R8 cleared by read", d, 8'h00);

      // R11 start in the middle of a data byte
      i2c_start(); send_byte(WA, a); send_byte(8'h04, a);
      for (int i = 0; i < 3; i++) begin
         sda_m = 1'b0; #Q; scl_m = 1; #Q; #Q; scl_m = 0; #Q;
      end
      i2c_start(); send_byte(WA, a);
      chk("R11 restart address ack", a, 1);
      send_byte(8'h04, a); send_byte(8'h03, a); i2c_stop();
      rd_at(8'h04, d); chk("R11 write after restart", d, 8'h03);
      #(Q);
      chk("R12 released after nack", sda_oe, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule